// File: doc/BRIEF.md
# Burst-Capable NOR Flash Bus Front-End

This block is the device side of a NOR-style flash bus. It watches five active-low control pins: chip enable, output enable, write enable, address strobe and reset. It also watches a mode input and a clock. The mode input stands in for the device's read-mode configuration, which lives elsewhere. From these pins the block serves words from an internal array in one of two ways:

- **Asynchronous mode:** the address is held when the address strobe rises, and the addressed word is shown while output enable is low.
- **Burst mode:** a clock edge with the strobe low loads a start address. Each later edge presents the next word in linear order, wrapping at the end of the array.

The data bus is modelled as a value and a drive-enable. The enable is low whenever the block is not presenting a word. Write cycles are not applied to the array. The block reports each one as a single-cycle strobe carrying the captured address and data. The array holds computed contents that are loaded at reset.

All pins are sampled on the rising edge of the clock. In asynchronous mode, the address follows the address bus on every edge where the strobe is low. It then stays frozen once the strobe is seen high, which is the value present when the strobe rose.

Top module: `flashBusFront`

## Requirements
- R1: While rstN is low, dqOe is 0 and wrStrobe is 0. Any burst in progress is abandoned: after release, clock edges with ceN low and advN high present nothing until a new load. At reset, array word i is ((i * 0x0123) ^ 0xC3A5) truncated to 16 bits, for i = 0 .. 2**DEPTH_LOG2-1.
- R2: While ceN is high, dqOe is 0, no write strobe is raised, and no burst is loaded. A later edge with ceN low and advN high therefore presents nothing.
- R3: With syncMode 0, the read address follows addrIn on every edge where ceN is low, weN is high and advN is low. It is held while advN is high. dqOut is the array word at the address modulo the array depth. dqOe is 1 exactly when rstN is high, ceN is low, oeN is low and weN is high.
- R4: With syncMode 1, an edge where ceN is low, advN is low and weN is high loads the burst start address (addrIn modulo the depth). dqOe is 0 after that edge.
- R5: After a load, each edge with ceN low, advN high and weN high advances the burst. dqOut then shows the word at the burst address and the address steps up by one. The first advance shows the start word. dqOe is 1 while oeN is low.
- R6: The burst address wraps from 2**DEPTH_LOG2-1 to 0.
- R7: oeN high during a burst forces dqOe to 0, but the burst address still steps on each advance edge.
- R8: An edge with ceN high ends the burst. Later edges with ceN low and advN high present nothing until a new load.
- R9: advN low on an edge during a burst drops the current burst and loads a new start address. dqOe is 0 after that edge, and later advances continue from the new address.
- R10: An edge with rstN high, ceN low, oeN high and weN low captures addrIn into wrAddr and dqIn into wrData, and raises wrStrobe for one cycle. This happens only when the previous edge did not meet the same condition. Holding the condition causes no further strobe or capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Hardware reset, active low |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| advN | input | 1 | Address strobe, active low |
| syncMode | input | 1 | 1 = clocked burst reads, 0 = asynchronous reads |
| addrIn | input | 21 | Address bus |
| dqIn | input | 16 | Data bus, inbound value |
| dqOut | output | 16 | Data bus, outbound value |
| dqOe | output | 1 | Data bus drive enable (0 = high impedance) |
| wrStrobe | output | 1 | One-cycle write-cycle indication |
| wrAddr | output | 21 | Address captured by the write cycle |
| wrData | output | 16 | Data captured by the write cycle |

## Verification
Two pairs of events can land on the same clock edge, and the bench provokes both:

- **Restart during a live burst:** a new start address arrives while the burst is still presenting words. The bench lowers the address strobe in the middle of a burst. It then checks that the bus drops its enable on the load edge and that the next words come from the new address.
- **Advance with output enable high:** an advance edge falls while output enable is high. A scoreboard queue holds only the words that should appear on the bus. The words skipped while output enable was high must not appear, yet the counter must have moved past them.

A monitor pops the queue on every edge where the bus is enabled, so any stray or missing word is reported.

// File: rtl/flashFrontPkg.sv
package flashFrontPkg;

  typedef struct packed {
    logic trackAddr;     // async mode: follow the address bus
    logic loadBurst;     // burst mode: load start address
    logic advance;       // burst mode: present word, step address
    logic captureWrite;  // first edge of a write cycle
  } strobes_t;

  function automatic logic [15:0] initWord(input int unsigned idx);
    logic [31:0] prod;
    prod = idx * 32'h0000_0123;
    return prod[15:0] ^ 16'hC3A5;
  endfunction

endpackage

// File: rtl/flashFrontCtl.sv
module flashFrontCtl
  import flashFrontPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     ceN,
  input  logic     oeN,
  input  logic     weN,
  input  logic     advN,
  input  logic     syncMode,
  output strobes_t strb,
  output logic     dqOe
);

  logic live;
  logic writeCond;
  logic burstLive;
  logic dataValid;
  logic writePrev;

  assign live      = rstN & ~ceN;
  assign writeCond = live & oeN & ~weN;

  always_comb begin
    strb.trackAddr    = live & ~syncMode & ~advN & weN;
    strb.loadBurst    = live &  syncMode & ~advN & weN;
    strb.advance      = live &  syncMode &  advN & weN & burstLive;
    strb.captureWrite = writeCond & ~writePrev;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstLive <= 1'b0;
      dataValid <= 1'b0;
      writePrev <= 1'b0;
    end else begin
      writePrev <= writeCond;
      if (!live || !syncMode) begin
        burstLive <= 1'b0;
        dataValid <= 1'b0;
      end else if (strb.loadBurst) begin
        burstLive <= 1'b1;
        dataValid <= 1'b0;
      end else if (strb.advance) begin
        dataValid <= 1'b1;
      end
    end
  end

  assign dqOe = rstN & ~ceN & ~oeN & weN & (~syncMode | dataValid);

endmodule

// File: rtl/flashFrontData.sv
module flashFrontData
  import flashFrontPkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int DATA_W     = 16,
  parameter int DEPTH_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic              syncMode,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [DATA_W-1:0]     mem [DEPTH];
  logic [DEPTH_LOG2-1:0] asyncIdx;
  logic [DEPTH_LOG2-1:0] burstPtr;
  logic [DATA_W-1:0]     burstWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(initWord(i));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asyncIdx  <= '0;
      burstPtr  <= '0;
      burstWord <= '0;
    end else begin
      if (strb.trackAddr) asyncIdx <= addrIn[DEPTH_LOG2-1:0];
      if (strb.loadBurst) begin
        burstPtr <= addrIn[DEPTH_LOG2-1:0];
      end else if (strb.advance) begin
        burstWord <= mem[burstPtr];
        burstPtr  <= burstPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrStrobe <= strb.captureWrite;
      if (strb.captureWrite) begin
        wrAddr <= addrIn;
        wrData <= dqIn;
      end
    end
  end

  assign dqOut = syncMode ? burstWord : mem[asyncIdx];

endmodule

// File: rtl/flashBusFront.sv
module flashBusFront
  import flashFrontPkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int DATA_W     = 16,
  parameter int DEPTH_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              advN,
  input  logic              syncMode,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  strobes_t strb;

  flashFrontCtl ctl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .advN(advN), .syncMode(syncMode), .strb(strb), .dqOe(dqOe)
  );

  flashFrontData #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)
  ) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .syncMode(syncMode),
    .addrIn(addrIn), .dqIn(dqIn), .dqOut(dqOut),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData)
  );

endmodule

// File: rtl/flashFrontChk.sv
module flashFrontChk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic              advN,
  input logic              syncMode,
  input logic [ADDR_W-1:0] addrIn,
  input logic [DATA_W-1:0] dqIn,
  input logic [DATA_W-1:0] dqOut,
  input logic              dqOe,
  input logic              wrStrobe,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData
);

  always_comb begin
    if (!rstN) begin
      p_reset_bus_off_r1: assert (dqOe == 1'b0);
    end
  end

  p_standby_bus_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> !dqOe);

  p_async_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!syncMode && $past(!syncMode) && $past(advN)) |-> $stable(dqOut));

  p_load_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (syncMode && !ceN && !advN && weN) |=> (!dqOe || !syncMode));

  p_oe_gates_bus_r7: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dqOe);

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  p_strobe_data_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (wrData == $past(dqIn) && wrAddr == $past(addrIn)));

endmodule

bind flashBusFront flashFrontChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .advN(advN),
  .syncMode(syncMode), .addrIn(addrIn), .dqIn(dqIn), .dqOut(dqOut),
  .dqOe(dqOe), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData)
);

// File: tb/flashBusFront_test.sv
module flashBusFront_test;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, oeN = 1'b1, weN = 1'b1, advN = 1'b1;
  logic        syncMode = 1'b0;
  logic [20:0] addrIn = '0;
  logic [15:0] dqIn = '0;
  logic [15:0] dqOut;
  logic        dqOe;
  logic        wrStrobe;
  logic [20:0] wrAddr;
  logic [15:0] wrData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit burstWatch = 1'b0;
  logic [15:0] expQ[$];
  int ptrModel = 0;

  always #2 clk = ~clk;

  flashBusFront uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .advN(advN),
    .syncMode(syncMode), .addrIn(addrIn), .dqIn(dqIn), .dqOut(dqOut),
    .dqOe(dqOe), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData)
  );

  function automatic logic [15:0] refWord(input int idx);
    logic [31:0] p;
    p = (idx % DEPTH) * 32'h123;
    return p[15:0] ^ 16'hC3A5;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected word for every enabled burst output edge
  always @(posedge clk) begin
    logic [15:0] e;
    #1;
    if (burstWatch && dqOe) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R5", "unexpected burst word", {16'h0, dqOut}, 32'h0);
      end else begin
        e = expQ.pop_front();
        chk(dqOut == e, "R5", "burst word", {16'h0, dqOut}, {16'h0, e});
      end
    end
  end

  task automatic burstLoad(input logic [20:0] a, input string req);
    advN = 1'b0;
    addrIn = a;
    @(negedge clk);
    chk(dqOe == 1'b0, req, "bus off after load edge", {31'h0, dqOe}, 32'h0);
    ptrModel = int'(a) % DEPTH;
    advN = 1'b1;
    addrIn = 21'h0A5A5A;
  endtask

  task automatic burstSteps(input int n, input bit oeLow);
    for (int k = 0; k < n; k++) begin
      oeN = !oeLow;
      if (oeLow) expQ.push_back(refWord(ptrModel));
      ptrModel = (ptrModel + 1) % DEPTH;
      @(negedge clk);
    end
  endtask

  initial begin
    // R1: reset state with write and read conditions on the pins
    repeat (2) @(negedge clk);
    ceN = 1'b0; oeN = 1'b1; weN = 1'b0;
    @(negedge clk);
    chk(wrStrobe == 1'b0, "R1", "no strobe in reset", {31'h0, wrStrobe}, 32'h0);
    oeN = 1'b0; weN = 1'b1;
    #1;
    chk(dqOe == 1'b0, "R1", "bus off in reset", {31'h0, dqOe}, 32'h0);
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    rstN = 1'b1;
    @(negedge clk);

    // R3: async read, address held from the strobe's rising edge
    syncMode = 1'b0; ceN = 1'b0; weN = 1'b1; advN = 1'b0; addrIn = 21'h1ABC05;
    @(negedge clk);
    advN = 1'b1; addrIn = 21'h000033;
    @(negedge clk);
    oeN = 1'b0;
    #1;
    chk(dqOe == 1'b1, "R3", "async bus enable", {31'h0, dqOe}, 32'h1);
    chk(dqOut == refWord(5), "R3", "async word idx 5", {16'h0, dqOut}, {16'h0, refWord(5)});
    @(negedge clk);
    chk(dqOut == refWord(5), "R3", "async word held", {16'h0, dqOut}, {16'h0, refWord(5)});
    advN = 1'b0; addrIn = 21'h0000FF;
    @(negedge clk);
    advN = 1'b1;
    @(negedge clk);
    chk(dqOut == refWord(63), "R3", "async word idx 63", {16'h0, dqOut}, {16'h0, refWord(63)});
    oeN = 1'b1;
    #1;
    chk(dqOe == 1'b0, "R3", "async bus off with oeN high", {31'h0, dqOe}, 32'h0);
    @(negedge clk);

    // R2: standby ignores everything
    ceN = 1'b1; oeN = 1'b0; weN = 1'b0; advN = 1'b0; syncMode = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk(dqOe == 1'b0, "R2", "bus off in standby", {31'h0, dqOe}, 32'h0);
      chk(wrStrobe == 1'b0, "R2", "no strobe in standby", {31'h0, wrStrobe}, 32'h0);
    end
    ceN = 1'b0; weN = 1'b1; advN = 1'b1;
    @(negedge clk);
    chk(dqOe == 1'b0, "R2", "no burst loaded in standby", {31'h0, dqOe}, 32'h0);

    // R4, R5: basic burst
    burstWatch = 1'b1;
    oeN = 1'b0;
    burstLoad(21'h100007, "R4");
    burstSteps(4, 1'b1);
    // R6: wrap at the top of the array
    burstLoad(21'h00003E, "R4");
    burstSteps(4, 1'b1);
    chk(dqOut == refWord(1), "R6", "word after wrap", {16'h0, dqOut}, {16'h0, refWord(1)});
    // R7: oeN high hides words, counter still steps
    burstLoad(21'h00000A, "R4");
    burstSteps(2, 1'b1);
    burstSteps(2, 1'b0);
    chk(dqOe == 1'b0, "R7", "bus off with oeN high", {31'h0, dqOe}, 32'h0);
    burstSteps(2, 1'b1);
    chk(dqOut == refWord(15), "R7", "counter advanced while hidden", {16'h0, dqOut}, {16'h0, refWord(15)});
    // R9: restart mid-burst
    burstLoad(21'h000014, "R4");
    burstSteps(2, 1'b1);
    burstLoad(21'h000028, "R9");
    burstSteps(3, 1'b1);
    // R8: chip enable high ends the burst
    ceN = 1'b1;
    @(negedge clk);
    chk(dqOe == 1'b0, "R8", "bus off on ceN high", {31'h0, dqOe}, 32'h0);
    ceN = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(dqOe == 1'b0, "R8", "no advance after end", {31'h0, dqOe}, 32'h0);
    end
    // R1: reset abandons a burst
    burstLoad(21'h000032, "R4");
    burstSteps(2, 1'b1);
    rstN = 1'b0;
    #1;
    chk(dqOe == 1'b0, "R1", "bus off on reset", {31'h0, dqOe}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk(dqOe == 1'b0, "R1", "burst abandoned after reset", {31'h0, dqOe}, 32'h0);
    end
    chk(expQ.size() == 0, "R5", "all expected words seen", expQ.size(), 32'h0);
    burstWatch = 1'b0;

    // R10: write cycles
    oeN = 1'b1; weN = 1'b0; advN = 1'b1; addrIn = 21'h15A5A5; dqIn = 16'hBEEF;
    @(negedge clk);
    chk(wrStrobe == 1'b1, "R10", "strobe raised", {31'h0, wrStrobe}, 32'h1);
    chk(wrAddr == 21'h15A5A5, "R10", "write address", {11'h0, wrAddr}, 32'h15A5A5);
    chk(wrData == 16'hBEEF, "R10", "write data", {16'h0, wrData}, 32'hBEEF);
    dqIn = 16'h1234;
    @(negedge clk);
    chk(wrStrobe == 1'b0, "R10", "single strobe while held", {31'h0, wrStrobe}, 32'h0);
    chk(wrData == 16'hBEEF, "R10", "no recapture while held", {16'h0, wrData}, 32'hBEEF);
    weN = 1'b1;
    @(negedge clk);
    weN = 1'b0; addrIn = 21'h000001; dqIn = 16'h0F0F;
    @(negedge clk);
    chk(wrStrobe == 1'b1 && wrData == 16'h0F0F && wrAddr == 21'h000001,
        "R10", "second write", {16'h0, wrData}, 32'h0F0F);
    weN = 1'b1; ceN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule